// File: doc/BRIEF.md
# Path Trace Byte Capture

This block sits on the receive side of a path overhead monitor and collects the path trace byte, one byte per frame, each marked by a valid strobe. A mode input picks one of two ways of collecting it. The long mode fills a 64-entry register file with 64 consecutive trace bytes and then stops until software-side control logic rearms it. The short mode looks for a 16-byte message that keeps repeating. It accepts that message into the register file only after it has arrived unchanged several times in a row.

In short mode the first byte of a message is the one with its most significant bit set. The block waits for such a byte before it starts to build a candidate message. Each following 16-byte instance is compared byte by byte against the candidate. A byte that differs raises a mismatch pulse, and the candidate is rebuilt from the message now arriving. The accepted contents are read through a combinational read port and stay as they are until a new message passes the consistency check.

Top module: `trace_capture`

## Requirements
- R1: After reset, `done` and `mismatch` are 0 and all 64 register file entries read 0.
- R2: `mode_short` = 0 selects 64-byte capture and `mode_short` = 1 selects 16-byte repeating-message capture.
- R3: In 64-byte mode, each byte with `byte_valid` = 1 is stored at the next address, from 0 up to 63, in arrival order. Cycles with `byte_valid` = 0 store nothing.
- R4: In 64-byte mode, `done` is high for exactly one cycle, starting the cycle after the 64th byte is stored. Later bytes are ignored until a `rearm` pulse, after which capture restarts at address 0.
- R5: In 16-byte mode, bytes are ignored until one arrives with bit 7 set. That byte becomes position 0 of the 16-byte window.
- R6: In 16-byte mode, a message is written to addresses 0..15 only at the end of its third consecutive identical instance. `done` pulses for one cycle at that point.
- R7: In 16-byte mode, a byte that differs from the candidate causes a one-cycle `mismatch` pulse in the next cycle. The message being received becomes the new candidate, with a run count of one.
- R8: Addresses 0..15 keep their contents until a message is accepted. Addresses 16..63 are never written in 16-byte mode.
- R9: A change of `mode_short` clears alignment, run count, capture address and the disarmed state, but leaves the register file as it is.
- R10: Further identical instances of an already accepted message do not pulse `done` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_short | input | 1 | 0: 64-byte capture, 1: 16-byte repeating-message capture |
| rearm | input | 1 | Restarts 64-byte capture at address 0 |
| byte_valid | input | 1 | Qualifies `byte_in` (one per frame) |
| byte_in | input | 8 | Received path trace byte |
| rd_addr | input | 6 | Register file read address |
| rd_data | output | 8 | Register file contents at `rd_addr` |
| done | output | 1 | One-cycle pulse when a capture completes or a message is accepted |
| mismatch | output | 1 | One-cycle pulse when a byte differs from the candidate |

## Verification
The assertions assume that `mode_short` changes only in cycles without a valid byte, and that `rearm` is not pulsed in the same cycle as a valid byte in 64-byte mode. The stimulus drives every input on the falling clock edge. It changes the mode and pulses rearm only while `byte_valid` is low, and it leaves an idle cycle after every trace byte. Short-mode messages are built so that only position 0 has bit 7 set, which keeps the window alignment fixed once it is found.

// File: rtl/trace_cap_pkg.sv
package trace_cap_pkg;

  // Next write position, wrapping at len.
  function automatic int unsigned wrap_inc(int unsigned idx, int unsigned len);
    return (idx + 1 == len) ? 0 : idx + 1;
  endfunction

  // Run count after a full instance: a fresh candidate starts at one,
  // a clean repeat counts up and saturates at limit.
  function automatic int unsigned next_run(int unsigned run, logic fresh, int unsigned limit);
    if (fresh) return 1;
    return (run < limit) ? run + 1 : run;
  endfunction

endpackage

// File: rtl/trace_long_cap.sv
module trace_long_cap
  import trace_cap_pkg::*;
#(
  parameter int LEN = 64,
  parameter int DW  = 8,
  localparam int AW = $clog2(LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clear,
  input  logic          rearm,
  input  logic          byte_valid,
  input  logic [DW-1:0] byte_in,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = AW'(LEN - 1);

  logic          armed_q;
  logic [AW-1:0] idx_q;
  logic          last_byte;

  assign wr_en     = en && !clear && armed_q && byte_valid;
  assign wr_addr   = idx_q;
  assign wr_data   = byte_in;
  assign last_byte = wr_en && (idx_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      idx_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (clear) begin
        armed_q <= 1'b1;
        idx_q   <= '0;
      end else if (en && rearm) begin
        armed_q <= 1'b1;
        idx_q   <= '0;
      end else if (wr_en) begin
        idx_q <= AW'(wrap_inc(32'(idx_q), LEN));
        if (last_byte) begin
          armed_q <= 1'b0;
          done_o  <= 1'b1;
        end
      end
    end
  end

  assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(last_byte));
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_disarmed_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !rearm && !clear) |-> !wr_en);

endmodule

// File: rtl/trace_short_sync.sv
module trace_short_sync
  import trace_cap_pkg::*;
#(
  parameter int LEN      = 16,
  parameter int DW       = 8,
  parameter int REPEAT_N = 3,
  localparam int IW = $clog2(LEN),
  localparam int CW = $clog2(REPEAT_N + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   clear,
  input  logic                   byte_valid,
  input  logic [DW-1:0]          byte_in,
  output logic                   load_en,
  output logic [LEN-1:0][DW-1:0] load_data,
  output logic                   done_o,
  output logic                   mismatch_o
);
  localparam logic [IW-1:0] LAST = IW'(LEN - 1);

  logic [LEN-1:0][DW-1:0] cand_q;
  logic [IW-1:0]          idx_q;
  logic [CW-1:0]          run_q;
  logic                   aligned_q;
  logic                   fresh_q;

  logic take, start_hit, cmp_hit, miss_ev, inst_end, end_fresh, rewrite;

  assign take      = en && !clear && byte_valid;
  assign start_hit = take && !aligned_q && byte_in[DW-1];
  assign cmp_hit   = (byte_in == cand_q[idx_q]);
  assign miss_ev   = take && aligned_q && !fresh_q && !cmp_hit;
  assign rewrite   = take && aligned_q && (fresh_q || miss_ev);
  assign inst_end  = take && aligned_q && (idx_q == LAST);
  assign end_fresh = fresh_q || miss_ev;
  assign load_en   = inst_end && !end_fresh && (run_q == CW'(REPEAT_N - 1));
  assign load_data = cand_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q     <= '0;
      idx_q      <= '0;
      run_q      <= '0;
      aligned_q  <= 1'b0;
      fresh_q    <= 1'b0;
      done_o     <= 1'b0;
      mismatch_o <= 1'b0;
    end else begin
      done_o     <= load_en;
      mismatch_o <= miss_ev;
      if (clear) begin
        idx_q     <= '0;
        run_q     <= '0;
        aligned_q <= 1'b0;
        fresh_q   <= 1'b0;
      end else if (start_hit) begin
        aligned_q <= 1'b1;
        cand_q[0] <= byte_in;
        idx_q     <= IW'(wrap_inc(0, LEN));
        run_q     <= '0;
        fresh_q   <= 1'b1;
      end else if (take && aligned_q) begin
        if (rewrite) cand_q[idx_q] <= byte_in;
        idx_q <= IW'(wrap_inc(32'(idx_q), LEN));
        if (inst_end) begin
          run_q   <= CW'(next_run(32'(run_q), end_fresh, REPEAT_N));
          fresh_q <= 1'b0;
        end else begin
          fresh_q <= end_fresh;
        end
      end
    end
  end

  assert_run_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= CW'(REPEAT_N));
  assert_mismatch_needs_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_o |-> $past(aligned_q));
  assert_accept_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (run_q == CW'(REPEAT_N)));
  assert_clear_resets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!aligned_q && run_q == '0));
  assert_no_align_no_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned_q |-> !load_en);

endmodule

// File: rtl/trace_store.sv
module trace_store #(
  parameter int LONG_LEN  = 64,
  parameter int SHORT_LEN = 16,
  parameter int DW        = 8,
  localparam int AW = $clog2(LONG_LEN)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [DW-1:0]                wr_data,
  input  logic                         load_en,
  input  logic [SHORT_LEN-1:0][DW-1:0] load_data,
  input  logic [AW-1:0]                rd_addr,
  output logic [DW-1:0]                rd_data
);
  logic [LONG_LEN-1:0][DW-1:0] mem_q;

  for (genvar i = 0; i < LONG_LEN; i++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(i));
    if (i < SHORT_LEN) begin : g_loadable
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mem_q[i] <= '0;
        else if (load_en) mem_q[i] <= load_data[i];
        else if (hit)     mem_q[i] <= wr_data;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   mem_q[i] <= '0;
        else if (hit) mem_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem_q[rd_addr];

  assert_no_dual_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && load_en));

endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import trace_cap_pkg::*;
#(
  parameter int DW        = 8,
  parameter int LONG_LEN  = 64,
  parameter int SHORT_LEN = 16,
  parameter int REPEAT_N  = 3,
  localparam int AW = $clog2(LONG_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_short,
  input  logic          rearm,
  input  logic          byte_valid,
  input  logic [DW-1:0] byte_in,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          mismatch
);
  logic                         mode_q;
  logic                         mode_chg;
  logic                         wr_en;
  logic [AW-1:0]                wr_addr;
  logic [DW-1:0]                wr_data;
  logic                         long_done;
  logic                         load_en;
  logic [SHORT_LEN-1:0][DW-1:0] load_data;
  logic                         short_done;
  logic                         short_mm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_short;
  end
  assign mode_chg = (mode_short != mode_q);

  trace_long_cap #(.LEN(LONG_LEN), .DW(DW)) u_long (
    .clk(clk), .rst_n(rst_n), .en(!mode_short), .clear(mode_chg), .rearm(rearm),
    .byte_valid(byte_valid), .byte_in(byte_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done_o(long_done)
  );

  trace_short_sync #(.LEN(SHORT_LEN), .DW(DW), .REPEAT_N(REPEAT_N)) u_short (
    .clk(clk), .rst_n(rst_n), .en(mode_short), .clear(mode_chg),
    .byte_valid(byte_valid), .byte_in(byte_in),
    .load_en(load_en), .load_data(load_data),
    .done_o(short_done), .mismatch_o(short_mm)
  );

  trace_store #(.LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_en(load_en), .load_data(load_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign done     = long_done | short_done;
  assign mismatch = short_mm;

  assert_load_only_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> mode_q);
  assert_write_only_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !mode_q);
  assert_single_done_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(long_done && short_done));
  assert_mismatch_short_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> $past(mode_short));

endmodule

// File: tb/test_trace_capture.sv
module test_trace_capture;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_short = 1'b0;
  logic       rearm = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_in = '0;
  logic [5:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       done, mismatch;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] exp_mem [64];
  int dones, mms, last_mm_pos;

  always #4 clk = ~clk;

  trace_capture i_trace_capture (
    .clk(clk), .rst_n(rst_n), .mode_short(mode_short), .rearm(rearm),
    .byte_valid(byte_valid), .byte_in(byte_in), .rd_addr(rd_addr),
    .rd_data(rd_data), .done(done), .mismatch(mismatch)
  );

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // One trace byte followed by one idle cycle; records the output pulses.
  task automatic send_byte(logic [7:0] b, int pos);
    @(negedge clk); byte_valid = 1'b1; byte_in = b;
    @(negedge clk); byte_valid = 1'b0;
    if (done) dones++;
    if (mismatch) begin mms++; last_mm_pos = pos; end
  endtask

  task automatic set_mode(logic m);
    @(negedge clk); mode_short = m;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_rearm();
    @(negedge clk); rearm = 1'b1;
    @(negedge clk); rearm = 1'b0;
  endtask

  task automatic check_mem(string req);
    for (int i = 0; i < 64; i++) begin
      rd_addr = 6'(i); #1;
      check(req, rd_data, exp_mem[i]);
    end
  endtask

  function automatic logic [7:0] long_byte(int seed, int i);
    return 8'((seed * 31 + i * 7 + 3) & 8'hFF);
  endfunction

  function automatic logic [7:0] msg_byte(int seed, int k);
    if (k == 0) return 8'(8'h80 | (seed & 8'h7F));
    return 8'((seed * 13 + k * 5 + 1) & 8'h7F);
  endfunction

  // One 16-byte instance; alt_pos >= 0 flips bit 0 of that byte.
  task automatic send_inst(int seed, int alt_pos);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] b;
      b = msg_byte(seed, k);
      if (k == alt_pos) b = b ^ 8'h01;
      send_byte(b, k);
    end
  endtask

  task automatic long_fill(int seed, string req);
    dones = 0;
    for (int i = 0; i < 64; i++) begin
      send_byte(long_byte(seed, i), i);
      exp_mem[i] = long_byte(seed, i);
      if (i < 63) check({req, " early done"}, int'(dones), 0);
    end
    check({req, " done after 64th"}, dones, 1);
    @(negedge clk); check({req, " done one cycle"}, int'(done), 0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 64; i++) exp_mem[i] = 8'h00;
    check("R1 done", int'(done), 0);
    check("R1 mismatch", int'(mismatch), 0);
    check_mem("R1 contents");
  endtask

  task automatic t_long();
    long_fill(1, "R4");
    check_mem("R3 first capture");
    dones = 0;
    send_byte(8'hEE, 0); send_byte(8'hDD, 1);
    check("R4 no done while disarmed", dones, 0);
    check_mem("R4 ignored after done");
    pulse_rearm();
    long_fill(2, "R4 rearm");
    check_mem("R3 after rearm");
  endtask

  task automatic t_short_accept();
    set_mode(1'b1);
    check_mem("R9 store kept across mode change");
    dones = 0; mms = 0;
    for (int i = 0; i < 5; i++) send_byte(8'(i + 1), i);
    check("R5 no mismatch before alignment", mms, 0);
    send_inst(5, -1); send_inst(5, -1);
    check("R6 no done after two instances", dones, 0);
    check_mem("R8 held before acceptance");
    send_inst(5, -1);
    check("R6 done after third instance", dones, 1);
    check("R7 no mismatch on clean repeats", mms, 0);
    for (int k = 0; k < 16; k++) exp_mem[k] = msg_byte(5, k);
    check_mem("R6 R8 accepted window only");
    dones = 0;
    send_inst(5, -1); send_inst(5, -1);
    check("R10 no repeat done", dones, 0);
  endtask

  task automatic t_short_mismatch();
    dones = 0; mms = 0; last_mm_pos = -1;
    send_inst(9, -1); send_inst(9, -1);
    check("R7 mismatch vs old pattern", mms, 1);
    check("R7 mismatch position", last_mm_pos, 0);
    mms = 0;
    send_inst(9, 5);
    check("R7 single mismatch", mms, 1);
    check("R7 mismatch at altered byte", last_mm_pos, 5);
    check("R7 no accept after break", dones, 0);
    check_mem("R8 held after mismatch");
    mms = 0;
    send_inst(9, 5);
    check("R7 new candidate counts one", dones, 0);
    send_inst(9, 5);
    check("R7 accept after restart", dones, 1);
    check("R7 no extra mismatch", mms, 0);
    for (int k = 0; k < 16; k++) exp_mem[k] = msg_byte(9, k) ^ ((k == 5) ? 8'h01 : 8'h00);
    check_mem("R7 new candidate stored");
  endtask

  task automatic t_mode_change();
    dones = 0;
    send_inst(20, -1); send_inst(20, -1);
    set_mode(1'b0); set_mode(1'b1);
    send_inst(20, -1); send_inst(20, -1);
    check("R9 run count cleared", dones, 0);
    send_inst(20, -1);
    check("R9 accept after fresh run", dones, 1);
    for (int k = 0; k < 16; k++) exp_mem[k] = msg_byte(20, k);
    check_mem("R9 short accept");
    set_mode(1'b0);
    dones = 0;
    for (int i = 0; i < 10; i++) send_byte(8'hA0 + 8'(i), i);
    for (int i = 0; i < 10; i++) exp_mem[i] = 8'hA0 + 8'(i);
    set_mode(1'b1); set_mode(1'b0);
    check_mem("R9 partial long capture kept");
    long_fill(3, "R9 long restarts at 0");
    check_mem("R2 R3 long mode after switch");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_long();
    t_short_accept();
    t_short_mismatch();
    t_mode_change();
    finish_run();
  end
endmodule